// File: doc/BRIEF.md
# Sector Erase Queue and Suspend Controller

This block gathers sector-erase requests for a memory split into eight equal sectors. It then runs the erase as a timed job that can be paused and resumed. An upstream command decoder hands it one event per write strobe:

- a sector-erase code that carries a sector index taken from the top address bits,
- a suspend code,
- any other command.

A per-sector protect mask keeps chosen sectors out of the job. The block drives a simulated erase engine with one-cycle start and halt requests. It reports the live target mask and three state flags.

The first sector-erase command opens a load window. Each accepted command inside the window restarts the window timer and ORs one more sector into the queue. When the window runs out with no new write, the erase starts. The job lasts a fixed number of cycles per unprotected queued sector. A suspend sent while the window is open closes the window at once. A suspend takes effect after a fixed latency. While the job is suspended, the sector-erase code resumes it, and any other command abandons it. In the state diagram below, those other commands are the "other" edges.

States and transitions:

- IDLE to LOAD on a sector command.
- LOAD to LOAD on a sector command, which adds the sector and restarts the timer.
- LOAD to RUN when the window expires.
- LOAD to HALTING on a suspend.
- RUN to HALTING on a suspend.
- HALTING to PAUSED when the latency expires.
- PAUSED to RUN on a sector command (resume).
- LOAD, RUN, HALTING or PAUSED to IDLE on an "other" command (abort).
- RUN or HALTING to IDLE when the work count is used up (done).

Top module: `sect_erase_ctrl`

## Requirements
- R1: After reset every output is low. In IDLE, an accepted sector command (cmd_kind 2'b01) enters LOAD. load_open then goes high and target_mask holds only bit N, where N is cmd_sect.
- R2: While LOAD is active, further sector commands OR their bit into the queue, in any order. Duplicates change nothing, and all eight sectors can be queued.
- R3: Every accepted command in LOAD restarts the window. load_open stays high for WIN_CYC cycles after the last command. In the next cycle erase_run is high and eng_start is high for that one cycle.
- R4: A sector command during RUN or HALTING is ignored. target_mask is unchanged and load_open stays low.
- R5: RUN with no commands lasts ERASE_CYC times the number of unprotected queued sectors, with a minimum of one cycle. The block then returns to IDLE with target_mask cleared.
- R6: target_mask never shows a sector whose protect_mask bit is set. Protected sectors add nothing to the erase length.
- R7: An "other" command (cmd_kind 2'b00 or 2'b11) in LOAD, RUN, HALTING or PAUSED aborts to IDLE. All flags go low and target_mask is cleared.
- R8: A suspend (cmd_kind 2'b10) in RUN pulses eng_halt for one cycle. erase_run stays high for SUSP_LAT cycles, and then suspended goes high and erase_run goes low.
- R9: A suspend in LOAD closes the window at once and follows the R8 sequence.
- R10: A suspend in HALTING or PAUSED is ignored. It neither restarts the latency nor leaves the suspended state.
- R11: A sector command in PAUSED resumes the job with an eng_start pulse. The sector index is ignored, and the remaining work is kept. The cycles spent in RUN and HALTING add up to one more than the R5 length.
- R12: A suspend in IDLE is ignored and all flags stay low.
- R13: While other_busy is high, every command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command event strobe |
| cmd_kind | input | 2 | 01 sector erase/resume, 10 suspend, 00 or 11 other |
| cmd_sect | input | 3 | Sector index, taken from the top address bits |
| other_busy | input | 1 | Byte program or chip erase in progress |
| protect_mask | input | 8 | Per-sector protect bits |
| target_mask | output | 8 | Queued sectors that are not protected |
| erase_run | output | 1 | Erase engine working (RUN or HALTING) |
| suspended | output | 1 | Erase suspended (PAUSED) |
| load_open | output | 1 | Load window open |
| eng_start | output | 1 | One-cycle start or resume request |
| eng_halt | output | 1 | One-cycle halt request |

## Verification
A wrong state shows up within one cycle of the next command. A lost queue bit shows on target_mask right away. A stale window or latency count moves the fall of load_open or the rise of suspended by whole cycles, and the bench catches that with exact-cycle samples. A progress count that is not kept across a suspend only shows at the end of the job. The bench therefore counts every erase_run cycle after a resume and compares the total with the work left.

// File: rtl/sect_erase_pkg.sv
package sect_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_HALTING,
        ST_PAUSED
    } seq_state_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_SECT,
        EV_SUSP,
        EV_OTHER
    } seq_event_t;

    function automatic seq_event_t decode_event(input logic valid, input logic busy,
                                                input logic [1:0] kind);
        if (!valid || busy) return EV_NONE;
        case (kind)
            2'b01:   return EV_SECT;
            2'b10:   return EV_SUSP;
            default: return EV_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/cyc_down.sv
module cyc_down #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sect_queue.sv
module sect_queue #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W = $clog2(NUM_SECT),
    localparam int CNT_W  = $clog2(NUM_SECT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                add,
    input  logic [SECT_W-1:0]   add_idx,
    input  logic [NUM_SECT-1:0] protect,
    output logic [NUM_SECT-1:0] target,
    output logic [CNT_W-1:0]    live_cnt
);
    logic [NUM_SECT-1:0] queued_q;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                queued_q[g] <= 1'b0;
            else if (clear)
                queued_q[g] <= 1'b0;
            else if (add && add_idx == SECT_W'(g))
                queued_q[g] <= 1'b1;
        end
        assign target[g] = queued_q[g] & ~protect[g];
    end

    always_comb begin
        live_cnt = '0;
        for (int i = 0; i < NUM_SECT; i++)
            live_cnt = live_cnt + CNT_W'(target[i]);
    end
endmodule

// File: rtl/sect_erase_ctrl.sv
module sect_erase_ctrl
    import sect_erase_pkg::*;
#(
    parameter int NUM_SECT  = 8,
    parameter int WIN_CYC   = 20,
    parameter int ERASE_CYC = 40,
    parameter int SUSP_LAT  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_kind,
    input  logic [$clog2(NUM_SECT)-1:0]  cmd_sect,
    input  logic                         other_busy,
    input  logic [NUM_SECT-1:0]          protect_mask,
    output logic [NUM_SECT-1:0]          target_mask,
    output logic                         erase_run,
    output logic                         suspended,
    output logic                         load_open,
    output logic                         eng_start,
    output logic                         eng_halt
);
    localparam int CNT_W  = $clog2(NUM_SECT + 1);
    localparam int WIN_W  = $clog2(WIN_CYC + 1);
    localparam int LAT_W  = $clog2(SUSP_LAT + 1);
    localparam int WORK_W = $clog2(ERASE_CYC * NUM_SECT + 1);
    localparam logic [WIN_W-1:0]  WIN_RELOAD = WIN_W'(WIN_CYC - 1);
    localparam logic [LAT_W-1:0]  LAT_RELOAD = LAT_W'(SUSP_LAT - 1);
    localparam logic [WORK_W-1:0] ERASE_W    = WORK_W'(ERASE_CYC);

    seq_state_t state_q, state_d;
    seq_event_t ev;

    logic q_clear, q_add;
    logic win_load, win_dec, win_zero;
    logic lat_load, lat_dec, lat_zero;
    logic work_load, work_dec, work_zero;
    logic [CNT_W-1:0]  live_cnt;
    logic [WORK_W-1:0] work_total, work_reload;
    logic start_q, halt_q;

    assign ev          = decode_event(cmd_valid, other_busy, cmd_kind);
    assign work_total  = ERASE_W * WORK_W'(live_cnt);
    assign work_reload = (work_total == '0) ? '0 : work_total - 1'b1;

    sect_queue #(.NUM_SECT(NUM_SECT)) queue_i (
        .clk(clk), .rst_n(rst_n), .clear(q_clear), .add(q_add), .add_idx(cmd_sect),
        .protect(protect_mask), .target(target_mask), .live_cnt(live_cnt)
    );

    cyc_down #(.W(WIN_W)) win_i (
        .clk(clk), .rst_n(rst_n), .load(win_load), .load_val(WIN_RELOAD),
        .dec(win_dec), .zero(win_zero)
    );

    cyc_down #(.W(LAT_W)) lat_i (
        .clk(clk), .rst_n(rst_n), .load(lat_load), .load_val(LAT_RELOAD),
        .dec(lat_dec), .zero(lat_zero)
    );

    cyc_down #(.W(WORK_W)) work_i (
        .clk(clk), .rst_n(rst_n), .load(work_load), .load_val(work_reload),
        .dec(work_dec), .zero(work_zero)
    );

    // Next-state and counter control
    always_comb begin
        state_d   = state_q;
        q_clear   = 1'b0;
        q_add     = 1'b0;
        win_load  = 1'b0;
        win_dec   = 1'b0;
        lat_load  = 1'b0;
        lat_dec   = 1'b0;
        work_load = 1'b0;
        work_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ev == EV_SECT) begin
                    state_d  = ST_LOAD;
                    q_add    = 1'b1;
                    win_load = 1'b1;
                end
            end
            ST_LOAD: begin
                if (ev == EV_SECT) begin
                    q_add    = 1'b1;
                    win_load = 1'b1;
                end else if (ev == EV_SUSP) begin
                    state_d   = ST_HALTING;
                    work_load = 1'b1;
                    lat_load  = 1'b1;
                end else if (ev == EV_OTHER) begin
                    state_d = ST_IDLE;
                    q_clear = 1'b1;
                end else if (win_zero) begin
                    state_d   = ST_RUN;
                    work_load = 1'b1;
                end else begin
                    win_dec = 1'b1;
                end
            end
            ST_RUN: begin
                if (ev == EV_SUSP) begin
                    state_d  = ST_HALTING;
                    lat_load = 1'b1;
                end else if (ev == EV_OTHER) begin
                    state_d = ST_IDLE;
                    q_clear = 1'b1;
                end else if (work_zero) begin
                    state_d = ST_IDLE;
                    q_clear = 1'b1;
                end else begin
                    work_dec = 1'b1;
                end
            end
            ST_HALTING: begin
                if (ev == EV_OTHER || work_zero) begin
                    state_d = ST_IDLE;
                    q_clear = 1'b1;
                end else begin
                    work_dec = 1'b1;
                    if (lat_zero) state_d = ST_PAUSED;
                    else          lat_dec = 1'b1;
                end
            end
            ST_PAUSED: begin
                if (ev == EV_SECT) begin
                    state_d = ST_RUN;
                end else if (ev == EV_OTHER) begin
                    state_d = ST_IDLE;
                    q_clear = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                q_clear = 1'b1;
            end
        endcase
    end

    // State register and request pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
            halt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
            halt_q  <= (state_d == ST_HALTING) && (state_q != ST_HALTING);
        end
    end

    // Outputs
    always_comb begin
        load_open = (state_q == ST_LOAD);
        erase_run = (state_q == ST_RUN) || (state_q == ST_HALTING);
        suspended = (state_q == ST_PAUSED);
        eng_start = start_q;
        eng_halt  = halt_q;
    end
endmodule

// File: rtl/sect_erase_ctrl_chk.sv
module sect_erase_ctrl_chk #(
    parameter int NUM_SECT = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid,
    input logic [1:0]                  cmd_kind,
    input logic [$clog2(NUM_SECT)-1:0] cmd_sect,
    input logic                        other_busy,
    input logic [NUM_SECT-1:0]         protect_mask,
    input logic [NUM_SECT-1:0]         target_mask,
    input logic                        erase_run,
    input logic                        suspended,
    input logic                        load_open,
    input logic                        eng_start,
    input logic                        eng_halt
);
    logic acc, is_sect, is_susp, is_oth, idle;
    assign acc     = cmd_valid && !other_busy;
    assign is_sect = acc && cmd_kind == 2'b01;
    assign is_susp = acc && cmd_kind == 2'b10;
    assign is_oth  = acc && (cmd_kind == 2'b00 || cmd_kind == 2'b11);
    assign idle    = !load_open && !erase_run && !suspended;

    AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        idle && is_sect |=> load_open);                                   // R1
    AST_START_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> erase_run && !load_open && !suspended);             // R3
    AST_LATE_SECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_run && is_sect |=> !load_open && !idle);                    // R4
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !idle && is_oth |=> idle && target_mask == '0);                   // R7
    AST_HALT_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_halt |-> erase_run && !suspended && !load_open);              // R8
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && is_susp |=> suspended);                              // R10
    AST_RESUME_START: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && is_sect |=> erase_run && eng_start);                 // R11
    AST_IDLE_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        idle && is_susp |=> idle);                                        // R12
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        idle && cmd_valid && other_busy |=> idle);                        // R13
endmodule

bind sect_erase_ctrl sect_erase_ctrl_chk #(.NUM_SECT(NUM_SECT)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_sect(cmd_sect), .other_busy(other_busy), .protect_mask(protect_mask),
    .target_mask(target_mask), .erase_run(erase_run), .suspended(suspended),
    .load_open(load_open), .eng_start(eng_start), .eng_halt(eng_halt)
);

// File: tb/sect_erase_ctrl_tb_top.sv
module sect_erase_ctrl_tb_top;
    localparam int W = 20;
    localparam int E = 40;
    localparam int L = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic [2:0] cmd_sect = 3'd0;
    logic       other_busy = 1'b0;
    logic [7:0] protect_mask = 8'h00;
    logic [7:0] target_mask;
    logic       erase_run, suspended, load_open, eng_start, eng_halt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sect_erase_ctrl #(.NUM_SECT(8), .WIN_CYC(W), .ERASE_CYC(E), .SUSP_LAT(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_sect(cmd_sect), .other_busy(other_busy), .protect_mask(protect_mask),
        .target_mask(target_mask), .erase_run(erase_run), .suspended(suspended),
        .load_open(load_open), .eng_start(eng_start), .eng_halt(eng_halt)
    );

    // kind, sector, expected target, expected load_open
    localparam logic [13:0] VEC [0:9] = '{
        {2'b01, 3'd4, 8'h10, 1'b1},
        {2'b01, 3'd0, 8'h11, 1'b1},
        {2'b01, 3'd4, 8'h11, 1'b1},
        {2'b01, 3'd7, 8'h91, 1'b1},
        {2'b01, 3'd2, 8'h95, 1'b1},
        {2'b01, 3'd6, 8'hD5, 1'b1},
        {2'b01, 3'd1, 8'hD7, 1'b1},
        {2'b01, 3'd5, 8'hF7, 1'b1},
        {2'b01, 3'd3, 8'hFF, 1'b1},
        {2'b11, 3'd0, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] k, input logic [2:0] s);
        cmd_valid = 1'b1;
        cmd_kind  = k;
        cmd_sect  = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic count_run(output int n);
        n = 0;
        while (erase_run && n < 5000) begin
            n++;
            cyc(1);
        end
    endtask

    function automatic logic [3:0] flags();
        return {load_open, erase_run, suspended, eng_start};
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int n;
        cyc(2);
        chk("R1 reset flags", {28'd0, flags()}, 32'h0);
        chk("R1 reset mask", {24'd0, target_mask}, 32'h0);
        rst_n = 1'b1;
        cyc(1);

        // Vector table: R1 entry, R2 accumulation, R7 abort in LOAD
        for (int i = 0; i < 10; i++) begin
            send(VEC[i][13:12], VEC[i][11:9]);
            chk("R1/R2/R7 vec mask", {24'd0, target_mask}, {24'd0, VEC[i][8:1]});
            chk("R1/R2/R7 vec open", {31'd0, load_open}, {31'd0, VEC[i][0]});
        end

        // R12 suspend in idle
        send(2'b10, 3'd0);
        chk("R12 idle suspend", {28'd0, flags()}, 32'h0);

        // R13 busy blocks commands
        other_busy = 1'b1;
        send(2'b01, 3'd2);
        chk("R13 busy ignore", {28'd0, flags()}, 32'h0);
        other_busy = 1'b0;

        // R3 window restart, R4 late sector, R5 length for two sectors
        send(2'b01, 3'd3);
        cyc(10);
        send(2'b01, 3'd6);
        cyc(W - 1);
        chk("R3 window held", {31'd0, load_open}, 32'd1);
        cyc(1);
        chk("R3 erase start", {28'd0, flags()}, 32'b0101);
        chk("R3 target", {24'd0, target_mask}, 32'h48);
        cyc(1);
        chk("R3 start pulse width", {31'd0, eng_start}, 32'd0);
        send(2'b01, 3'd0);
        chk("R4 late sector mask", {24'd0, target_mask}, 32'h48);
        chk("R4 no reopen", {31'd0, load_open}, 32'd0);
        count_run(n);
        chk("R5 two-sector length", n, 78);
        chk("R5 mask cleared", {24'd0, target_mask}, 32'h0);

        // R6 protected sector dropped from mask and length
        protect_mask = 8'h04;
        send(2'b01, 3'd2);
        send(2'b01, 3'd5);
        cyc(W - 1);
        chk("R6 protected hidden", {24'd0, target_mask}, 32'h20);
        cyc(1);
        count_run(n);
        chk("R6 length unprotected only", n, E);
        protect_mask = 8'h01;
        send(2'b01, 3'd0);
        cyc(W);
        chk("R6 all protected mask", {24'd0, target_mask}, 32'h0);
        chk("R5 minimum one cycle", {31'd0, erase_run}, 32'd1);
        cyc(1);
        chk("R5 minimum done", {31'd0, erase_run}, 32'd0);
        protect_mask = 8'h00;

        // R8 suspend latency, R10 repeat ignored, R11 resume keeps progress
        send(2'b01, 3'd1);
        cyc(W);
        cyc(5);
        send(2'b10, 3'd0);
        chk("R8 halt pulse", {30'd0, eng_halt, erase_run}, 32'b11);
        cyc(L - 1);
        chk("R8 latency run", {30'd0, erase_run, suspended}, 32'b10);
        cyc(1);
        chk("R8 suspended", {30'd0, erase_run, suspended}, 32'b01);
        send(2'b10, 3'd0);
        chk("R10 repeat suspend", {31'd0, suspended}, 32'd1);
        send(2'b01, 3'd4);
        chk("R11 resume start", {30'd0, eng_start, erase_run}, 32'b11);
        chk("R11 index ignored", {24'd0, target_mask}, 32'h02);
        count_run(n);
        chk("R11 remaining work", n, E - 5 - L);

        // R9 suspend in window, R7 abort from PAUSED
        send(2'b01, 3'd3);
        cyc(3);
        send(2'b10, 3'd0);
        chk("R9 window closed", {29'd0, load_open, erase_run, eng_halt}, 32'b011);
        cyc(L);
        chk("R9 suspended", {31'd0, suspended}, 32'd1);
        send(2'b00, 3'd0);
        chk("R7 abort paused", {28'd0, flags()}, 32'h0);
        chk("R7 abort mask", {24'd0, target_mask}, 32'h0);

        // R7 abort in RUN
        send(2'b01, 3'd7);
        cyc(W + 3);
        send(2'b11, 3'd0);
        chk("R7 abort run", {20'd0, flags(), target_mask}, 32'h0);

        // R10 suspend in HALTING does not restart latency
        send(2'b01, 3'd0);
        cyc(W);
        send(2'b10, 3'd0);
        cyc(2);
        send(2'b10, 3'd0);
        cyc(L - 4);
        chk("R10 halting pre", {31'd0, suspended}, 32'd0);
        cyc(1);
        chk("R10 latency kept", {31'd0, suspended}, 32'd1);
        send(2'b00, 3'd0);
        chk("R7 final idle", {28'd0, flags()}, 32'h0);

        report();
    end
endmodule